// File: doc/BRIEF.md
# Low-Speed USB Line Transmitter

This block turns a packet of bytes into the differential line signalling of a low-speed USB link. After a start strobe with a byte count, it takes the bus and drives the idle level for one bit time. It then sends a fixed sync byte followed by the data bytes. Bits go out least significant first, are NRZI-encoded and carry stuffed bits. The packet ends with an end-of-packet sequence, after which both lines are released. Packet content such as the PID and CRC comes from upstream, and the receive path lives elsewhere.

Data bytes arrive on a valid/ready stream. The block raises `byte_ready` while its single holding register is empty and bytes remain to be fetched. A byte moves on any clock edge where `byte_valid` and `byte_ready` are both high. The source may stall, but it must deliver each byte before the byte ahead of it has finished shifting, which gives it eight bit times. A pending device address can be written at any time. It becomes the active address when the bus is released, but only after a data packet.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `oe`, `dp_out`, `dm_out`, `busy` and `byte_ready` are low and `dev_addr` is zero.
- R2: A `start` is accepted only while `busy` is low and only with `byte_cnt` in 2..12. A `start` sent while `busy` is high, or with a count outside that range, changes nothing on the outputs.
- R3: In the cycle after an accepted start, `oe` is low with `dm_out` high and `dp_out` low. `oe` rises on the next cycle, and the J level (dp=0, dm=1) is held for one bit time of CLKS_PER_BIT cycles.
- R4: The symbols that follow are the sync byte 0x80 and then `byte_cnt`-1 data bytes, each sent LSB first. A 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the level. Each symbol lasts CLKS_PER_BIT cycles.
- R5: After six consecutive 1 bits, one toggle symbol is inserted. The run count carries across byte boundaries and also applies after the final data bit.
- R6: After the last symbol, SE0 (dp=0, dm=0) is driven for two bit times and then J for one bit time. After that, `oe` falls and both line outputs are low.
- R7: Exactly `byte_cnt`-1 bytes are taken from the stream, and `byte_ready` is never high while `busy` is low.
- R8: `busy` is high exactly while `oe` is high.
- R9: `addr_we` loads `addr_in` as the pending address. `dev_addr` takes the pending value at the edge where `oe` falls, but only when `byte_cnt` was above 2. After a two-byte handshake packet, `dev_addr` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet |
| byte_cnt | input | CNT_W | Packet length including sync |
| byte_data | input | 8 | Stream data byte |
| byte_valid | input | 1 | Stream byte present |
| byte_ready | output | 1 | Holding register can take a byte |
| addr_we | input | 1 | Write pending address |
| addr_in | input | ADDR_W | Pending address value |
| dev_addr | output | ADDR_W | Active device address |
| busy | output | 1 | Bus owned by the transmitter |
| oe | output | 1 | Line driver enable |
| dp_out | output | 1 | D+ drive level |
| dm_out | output | 1 | D- drive level |

## Verification
A wrong bit-position or stuff-run state shows up as a wrong line level in the very next symbol slot. Because NRZI encoding is relative, that error then inverts every later level in the packet. A bad byte-fetch count shows either as stale data a byte later or as a wrong number of stream transfers when the packet ends. A misrouted address commit appears on `dev_addr` at the edge where the bus is released. The bench compares every symbol slot against its own encoder model, so each of these faults is caught within one bit time of its first effect.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_OWN, ST_DATA, ST_SE0, ST_JEND
  } tx_state_e;
  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
  parameter int CLKS_PER_BIT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [W-1:0] LAST = W'(CLKS_PER_BIT - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else if (run)          cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/usbtx_nrzi_stuff.sv
module usbtx_nrzi_stuff #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic bit_in,
  output logic stuff_due,
  output logic level_j
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic [OW-1:0] ones;

  assign stuff_due = (ones == OW'(STUFF_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones    <= '0;
      level_j <= 1'b1;
    end else if (clear) begin
      ones    <= '0;
      level_j <= 1'b1;
    end else if (step) begin
      if (stuff_due || !bit_in) begin
        ones    <= '0;
        level_j <= ~level_j;
      end else begin
        ones <= ones + OW'(1);
      end
    end
  end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 11,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int CNT_W        = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W       = 7,
  parameter int STUFF_RUN    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [7:0]        byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              busy,
  output logic              oe,
  output logic              dp_out,
  output logic              dm_out
);
  localparam logic [CNT_W-1:0] LO_CNT  = CNT_W'(MIN_BYTES);
  localparam logic [CNT_W-1:0] HI_CNT  = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  tx_state_e         state;
  logic              oe_q;
  logic              short_pkt;
  logic [CNT_W-1:0]  fetch_left;
  logic [CNT_W-1:0]  load_left;
  logic [7:0]        shreg;
  logic [7:0]        hold;
  logic              hold_full;
  logic [2:0]        bit_idx;
  logic              all_sent;
  logic              se0_second;
  logic [ADDR_W-1:0] pend_addr;

  logic tick, stuff_due, level_j;
  logic timer_run, emit_slot, step, take_bit, accept;

  assign accept     = (state == ST_IDLE) && start &&
                      (byte_cnt >= LO_CNT) && (byte_cnt <= HI_CNT);
  assign timer_run  = (state != ST_IDLE) && (state != ST_PREP);
  assign emit_slot  = tick && ((state == ST_OWN) || (state == ST_DATA));
  assign step       = emit_slot && (stuff_due || !all_sent);
  assign take_bit   = step && !stuff_due;
  assign byte_ready = oe_q && !hold_full && (fetch_left != '0);
  assign busy       = oe_q;
  assign oe         = oe_q;

  usbtx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_PREP),
    .run(timer_run), .tick(tick)
  );

  usbtx_nrzi_stuff #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_PREP),
    .step(step), .bit_in(shreg[0]),
    .stuff_due(stuff_due), .level_j(level_j)
  );

  // Line levels per state: J = dp 0 / dm 1, K = dp 1 / dm 0, SE0 = both 0
  always_comb begin
    dp_out = 1'b0;
    dm_out = 1'b0;
    unique case (state)
      ST_PREP, ST_JEND: dm_out = 1'b1;
      ST_OWN, ST_DATA: begin
        dp_out = ~level_j;
        dm_out = level_j;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_addr <= '0;
    else if (addr_we) pend_addr <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b0;
    end else if (byte_valid && byte_ready) begin
      hold      <= byte_data;
      hold_full <= 1'b1;
    end else if (take_bit && (bit_idx == 3'd7) && (load_left != '0)) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      oe_q       <= 1'b0;
      short_pkt  <= 1'b0;
      fetch_left <= '0;
      load_left  <= '0;
      shreg      <= '0;
      bit_idx    <= '0;
      all_sent   <= 1'b0;
      se0_second <= 1'b0;
      dev_addr   <= '0;
    end else begin
      if (byte_valid && byte_ready) fetch_left <= fetch_left - ONE_CNT;
      unique case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_PREP;
          short_pkt  <= (byte_cnt == LO_CNT);
          fetch_left <= byte_cnt - ONE_CNT;
          load_left  <= byte_cnt - ONE_CNT;
          shreg      <= SYNC_BYTE;
          bit_idx    <= '0;
          all_sent   <= 1'b0;
        end
        ST_PREP: begin
          state <= ST_OWN;
          oe_q  <= 1'b1;
        end
        ST_OWN, ST_DATA: if (emit_slot) begin
          if (state == ST_OWN) state <= ST_DATA;
          if (take_bit) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx != 3'd7) begin
              shreg <= shreg >> 1;
            end else if (load_left != '0) begin
              shreg     <= hold;
              load_left <= load_left - ONE_CNT;
            end else begin
              all_sent <= 1'b1;
            end
          end else if (!step) begin
            state      <= ST_SE0;
            se0_second <= 1'b0;
          end
        end
        ST_SE0: if (tick) begin
          if (se0_second) state <= ST_JEND;
          else se0_second <= 1'b1;
        end
        ST_JEND: if (tick) begin
          state <= ST_IDLE;
          oe_q  <= 1'b0;
          if (!short_pkt) dev_addr <= pend_addr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic              busy,
  input logic              byte_ready,
  input logic              dp_out,
  input logic              dm_out,
  input logic [ADDR_W-1:0] dev_addr
);
  // R3
  own_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dm_out) && !$past(dp_out)));

  // R4
  no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !(dp_out && dm_out));

  // R6
  release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> ($past(dm_out) && !$past(dp_out) && !dp_out && !dm_out));

  // R7
  ready_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> busy);

  // R9
  addr_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> $fell(oe));
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe(oe), .busy(busy), .byte_ready(byte_ready),
  .dp_out(dp_out), .dm_out(dm_out), .dev_addr(dev_addr)
);

// File: tb/test_usb_ls_tx.sv
module test_usb_ls_tx;
  localparam int CPB = 11;
  localparam int CNT_W = 4;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0;
  logic byte_ready;
  logic addr_we = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] dev_addr;
  logic busy, oe, dp_out, dm_out;

  int tests = 0;
  int fails = 0;
  logic [2:0] exp_q[$];
  logic [7:0] pkt_mem[12];
  int src_idx = 0;
  int src_n = 0;
  bit xfer_pend = 0;

  always #10 clk = ~clk;

  usb_ls_tx #(.CLKS_PER_BIT(CPB), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_usb_ls_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .addr_we(addr_we), .addr_in(addr_in), .dev_addr(dev_addr), .busy(busy),
    .oe(oe), .dp_out(dp_out), .dm_out(dm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream source: a transfer happens at the edge after a negedge with valid && ready
  initial forever begin
    @(negedge clk);
    if (xfer_pend) src_idx++;
    if (src_idx < src_n) begin
      byte_valid = 1'b1;
      byte_data  = pkt_mem[src_idx + 1];
    end else begin
      byte_valid = 1'b0;
    end
    xfer_pend = byte_valid && byte_ready;
  end

  // monitor: one sample near the middle of every symbol slot, items are {oe,dp,dm}
  initial forever begin
    @(posedge oe);
    repeat (CPB / 2 + 1) @(negedge clk);
    while (exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      check({oe, dp_out, dm_out} == e, "R4/R5/R6 line symbol", {oe, dp_out, dm_out}, e);
      check(busy == oe, "R8 busy tracks oe", busy, oe);
      if (exp_q.size() > 0) repeat (CPB) @(negedge clk);
    end
  end

  // driver: build the expected symbol stream, then launch the packet
  task automatic send_pkt(input int n, input bit poke_start);
    logic lvl;
    int ones;
    lvl = 1'b1;
    ones = 0;
    pkt_mem[0] = 8'h80;
    exp_q.push_back(3'b101);
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (pkt_mem[b][i] == 1'b0) begin lvl = ~lvl; ones = 0; end
        else ones++;
        exp_q.push_back({1'b1, ~lvl, lvl});
        if (ones == 6) begin
          lvl = ~lvl;
          ones = 0;
          exp_q.push_back({1'b1, ~lvl, lvl});
        end
      end
    end
    exp_q.push_back(3'b100);
    exp_q.push_back(3'b100);
    exp_q.push_back(3'b101);
    exp_q.push_back(3'b000);
    src_idx = 0;
    src_n = n - 1;
    @(negedge clk);
    start = 1'b1;
    byte_cnt = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    // R3 J preset before the enable
    check(!oe && dm_out && !dp_out, "R3 J preset", {oe, dp_out, dm_out}, 3'b001);
    @(negedge clk);
    check(oe, "R3 oe after preset", oe, 1);
    if (poke_start) begin
      repeat (5 * CPB) @(negedge clk);
      start = 1'b1;
      byte_cnt = CNT_W'(5);
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (CPB + 2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all symbols seen", exp_q.size(), 0);
    check(src_idx == n - 1, "R7 transfer count", src_idx, n - 1);
    check(!busy, "R2 no restart from ignored start", busy, 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({oe, dp_out, dm_out, busy, byte_ready} == 5'b0, "R1 outputs", {oe, dp_out, dm_out, busy, byte_ready}, 0);
    check(dev_addr == '0, "R1 dev_addr", dev_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 out-of-range counts ignored
    for (int k = 0; k < 2; k++) begin
      start = 1'b1;
      byte_cnt = (k == 0) ? CNT_W'(1) : CNT_W'(13);
      @(negedge clk);
      start = 1'b0;
      check(!dm_out && !oe, "R2 bad count no preset", {oe, dm_out}, 0);
      repeat (3) @(negedge clk);
      check(!busy && !byte_ready, "R2 bad count ignored", busy, 0);
    end

    // R9 pending address, then a handshake leaves dev_addr alone
    addr_we = 1'b1;
    addr_in = 7'h2A;
    @(negedge clk);
    addr_we = 1'b0;
    pkt_mem[1] = 8'hD2;
    send_pkt(2, 0);
    check(dev_addr == 7'h00, "R9 handshake keeps address", dev_addr, 0);

    // R4 plain data, R2 start during busy ignored
    pkt_mem[1] = 8'hC3; pkt_mem[2] = 8'h5A; pkt_mem[3] = 8'h00;
    send_pkt(4, 1);
    check(dev_addr == 7'h2A, "R9 data packet commits address", dev_addr, 7'h2A);

    // R5 stuffing across a byte boundary (0xE0 then 0x07) and at packet end (0xFC)
    addr_we = 1'b1;
    addr_in = 7'h11;
    @(negedge clk);
    addr_we = 1'b0;
    pkt_mem[1] = 8'hE0; pkt_mem[2] = 8'h07; pkt_mem[3] = 8'hFF; pkt_mem[4] = 8'hFC;
    send_pkt(5, 0);
    check(dev_addr == 7'h11, "R9 second commit", dev_addr, 7'h11);

    // R7 full-length packet
    for (int i = 1; i < 12; i++) pkt_mem[i] = 8'(i * 37 + 5);
    send_pkt(12, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule